// File: doc/BRIEF.md
# Disk Controller Transfer Buffer

This block is a byte-wide buffer between the host bus and the disk controller core. Command parameter bytes and disk data bytes all pass through it. A direction input names which side fills the buffer. The host side is paced by two status outputs. The request-for-master flag (`rqm`) says the host may move one byte now. The direction flag (`dio`) says whether that byte is read or written. The core side moves one byte per strobe, at the disk data rate.

After any reset the buffer runs in bypass mode and behaves as a one-byte holding register. The buffer's enable state and service threshold change only through a configure strobe from the command path. In buffered mode all sixteen entries are in use. A service request is raised when the pending data or the free space reaches the threshold. This lets the host tolerate a service delay of about the threshold times one byte time, minus 1.5 µs. Faults on the core side are recorded in sticky flags.

Top module: `xfer_fifo`

## Requirements
- R1: Bytes leave the buffer in the order they entered. `host_rdata` and `core_rdata` both show the oldest byte. `fill_level` shows the number of bytes held, up to 16 in buffered mode.
- R2: Any reset gives bypass mode, level 0, both fault flags clear, `rqm`=1 when `to_host`=0 and `svc_req`=1.
- R3: In bypass mode the capacity is one byte. A second write is ignored.
- R4: A `cfg_valid` pulse loads the enable state and the threshold. It empties the buffer and clears both fault flags. Nothing else changes the enable state or the threshold.
- R5: The threshold ranges from 1 to 15. A configured value of 0 acts as 1. In bypass mode the threshold is 1.
- R6: `dio` equals `to_host`. When `dio`=1, `rqm` is 1 exactly when the buffer is not empty. When `dio`=0, `rqm` is 1 exactly when the buffer is not full.
- R7: A host write is ignored when `dio`=1 or `rqm`=0. A host read is ignored when `dio`=0 or `rqm`=0. A core write is ignored when `to_host`=0, and a core read is ignored when `to_host`=1.
- R8: With `to_host`=1, `svc_req` is 1 exactly when the level is at or above the threshold.
- R9: With `to_host`=0, `svc_req` is 1 exactly when the free space (capacity minus level) is at or above the threshold.
- R10: A core write into a full buffer (with `to_host`=1) is dropped and sets `overrun`. The flag stays set until a reset or a configure pulse.
- R11: A core read from an empty buffer (with `to_host`=0) sets `underrun`. The flag stays set until a reset or a configure pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_valid | input | 1 | Configure strobe from the command path |
| cfg_enable | input | 1 | 1 selects buffered mode, 0 selects bypass mode |
| cfg_thresh | input | 4 | Service threshold, 0 treated as 1 |
| to_host | input | 1 | 1: core fills and host drains (disk read); 0: host fills and core drains |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Oldest byte, as seen by the host |
| core_wr | input | 1 | Core write strobe |
| core_wdata | input | 8 | Core write byte |
| core_rd | input | 1 | Core read strobe |
| core_rdata | output | 8 | Oldest byte, as seen by the core |
| rqm | output | 1 | Host may move one byte now |
| dio | output | 1 | 1: host reads; 0: host writes |
| svc_req | output | 1 | Service request, raised at the threshold |
| fill_level | output | 5 | Bytes held |
| overrun | output | 1 | Sticky flag: core wrote into a full buffer |
| underrun | output | 1 | Sticky flag: core read from an empty buffer |

## Verification
The bench builds the block with its default depth of 16 and a byte width of 8. This makes the full and one-short-of-full levels reachable within a few dozen strobes. It programs the thresholds 4, 8, 15 and 0. The threshold of 15 places the request edge one byte below full. The threshold of 0 exercises the clamp to 1. The bench also covers bypass mode before and after a configure pulse, in both directions, so it hits the one-byte capacity, the blocking of host strobes by `rqm`, and both sticky fault flags.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;
  typedef enum logic {
    DIR_TO_CORE = 1'b0,
    DIR_TO_HOST = 1'b1
  } xfer_dir_e;

  function automatic int unsigned ptr_w(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/xfer_fifo_store.sv
module xfer_fifo_store
  import xfer_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = ptr_w(DEPTH),
  localparam int unsigned LW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head,
  output logic [LW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] level_q, level_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
    end else begin
      if (push) wr_ptr_d = bump(wr_ptr_q);
      if (pop)  rd_ptr_d = bump(rd_ptr_q);
      case ({push, pop})
        2'b10:   level_d = level_q + LW'(1);
        2'b01:   level_d = level_q - LW'(1);
        default: level_d = level_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr_q] <= wdata;
  end

  assign head  = mem[rd_ptr_q];
  assign level = level_q;

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(DEPTH));

  // R10
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> level_q != LW'(DEPTH));
endmodule

// File: rtl/xfer_fifo_ctrl.sv
module xfer_fifo_ctrl
  import xfer_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = ptr_w(DEPTH),
  localparam int unsigned LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_valid,
  input  logic          cfg_enable,
  input  logic [AW-1:0] cfg_thresh,
  input  logic          to_host,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          core_wr,
  input  logic          core_rd,
  input  logic [LW-1:0] level,
  output logic          push,
  output logic          pop,
  output logic          flush,
  output logic          rqm,
  output logic          dio,
  output logic          svc_req,
  output logic          overrun,
  output logic          underrun
);
  logic          en_q, en_d;
  logic [AW-1:0] thr_q, thr_d;
  logic          ovr_q, ovr_d, und_q, und_d;
  logic [LW-1:0] cap, thr_eff, free;
  logic          empty, full, ovr_set, und_set;
  xfer_dir_e     dir;

  assign dir     = xfer_dir_e'(to_host);
  assign cap     = en_q ? LW'(DEPTH) : LW'(1);
  assign thr_eff = en_q ? {1'b0, thr_q} : LW'(1);
  assign free    = cap - level;
  assign empty   = (level == '0);
  assign full    = (level == cap);

  always_comb begin
    push    = 1'b0;
    pop     = 1'b0;
    ovr_set = 1'b0;
    und_set = 1'b0;
    if (!cfg_valid) begin
      if (dir == DIR_TO_HOST) begin
        push    = core_wr && !full;
        ovr_set = core_wr && full;
        pop     = host_rd && !empty;
      end else begin
        push    = host_wr && !full;
        pop     = core_rd && !empty;
        und_set = core_rd && empty;
      end
    end
  end

  always_comb begin
    en_d  = en_q;
    thr_d = thr_q;
    ovr_d = ovr_q | ovr_set;
    und_d = und_q | und_set;
    if (cfg_valid) begin
      en_d  = cfg_enable;
      thr_d = (cfg_thresh == '0) ? AW'(1) : cfg_thresh;
      ovr_d = 1'b0;
      und_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      thr_q <= AW'(1);
      ovr_q <= 1'b0;
      und_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      thr_q <= thr_d;
      ovr_q <= ovr_d;
      und_q <= und_d;
    end
  end

  assign flush    = cfg_valid;
  assign dio      = (dir == DIR_TO_HOST);
  assign rqm      = (dir == DIR_TO_HOST) ? !empty : !full;
  assign svc_req  = (dir == DIR_TO_HOST) ? (level >= thr_eff) : (free >= thr_eff);
  assign overrun  = ovr_q;
  assign underrun = und_q;

  // R10
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !cfg_valid) |=> ovr_q);

  // R11
  und_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (und_q && !cfg_valid) |=> und_q);

  // R6
  rqm_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rqm && dio) |-> level != '0);

  // R3
  bypass_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> level <= LW'(1));
endmodule

// File: rtl/xfer_fifo.sv
module xfer_fifo
  import xfer_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = ptr_w(DEPTH),
  localparam int unsigned LW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic             cfg_enable,
  input  logic [AW-1:0]    cfg_thresh,
  input  logic             to_host,
  input  logic             host_wr,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             host_rd,
  output logic [WIDTH-1:0] host_rdata,
  input  logic             core_wr,
  input  logic [WIDTH-1:0] core_wdata,
  input  logic             core_rd,
  output logic [WIDTH-1:0] core_rdata,
  output logic             rqm,
  output logic             dio,
  output logic             svc_req,
  output logic [LW-1:0]    fill_level,
  output logic             overrun,
  output logic             underrun
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             push, pop, flush;
  logic [WIDTH-1:0] wdata, head;
  logic [LW-1:0]    level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign wdata = to_host ? core_wdata : host_wdata;

  xfer_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_int_n),
    .cfg_valid(cfg_valid), .cfg_enable(cfg_enable), .cfg_thresh(cfg_thresh),
    .to_host(to_host), .host_wr(host_wr), .host_rd(host_rd),
    .core_wr(core_wr), .core_rd(core_rd), .level(level),
    .push(push), .pop(pop), .flush(flush),
    .rqm(rqm), .dio(dio), .svc_req(svc_req),
    .overrun(overrun), .underrun(underrun)
  );

  xfer_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) store_i (
    .clk(clk), .rst_n(rst_int_n),
    .push(push), .pop(pop), .flush(flush),
    .wdata(wdata), .head(head), .level(level)
  );

  assign host_rdata = head;
  assign core_rdata = head;
  assign fill_level = level;
endmodule

// File: tb/xfer_fifo_tb_top.sv
module xfer_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_valid, cfg_enable, to_host;
  logic [3:0] cfg_thresh;
  logic       host_wr, host_rd, core_wr, core_rd;
  logic [7:0] host_wdata, core_wdata, host_rdata, core_rdata;
  logic       rqm, dio, svc_req, overrun, underrun;
  logic [4:0] fill_level;
  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  xfer_fifo dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_enable(cfg_enable), .cfg_thresh(cfg_thresh),
    .to_host(to_host),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .core_wr(core_wr), .core_wdata(core_wdata), .core_rd(core_rd), .core_rdata(core_rdata),
    .rqm(rqm), .dio(dio), .svc_req(svc_req), .fill_level(fill_level),
    .overrun(overrun), .underrun(underrun)
  );

  // op codes: 0 idle, 1 configure (arg[4]=enable, arg[3:0]=threshold),
  // 2 set direction (arg[0]), 3 host write, 4 host read, 5 core write, 6 core read
  // row: op[19:17] arg[16:9] level[8:4] svc[3] rqm[2] overrun[1] underrun[0]
  localparam int NV = 20;
  localparam logic [19:0] VEC [NV] = '{
    {3'd0, 8'h00, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd3, 8'hA1, 5'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd3, 8'hB2, 5'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd6, 8'h00, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd2, 8'h01, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd5, 8'h11, 5'd1, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd5, 8'h22, 5'd1, 1'b1, 1'b1, 1'b1, 1'b0},
    {3'd4, 8'h00, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd1, 8'h14, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd5, 8'h01, 5'd1, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd5, 8'h02, 5'd2, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd5, 8'h03, 5'd3, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd5, 8'h04, 5'd4, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd4, 8'h00, 5'd3, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd2, 8'h00, 5'd3, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd6, 8'h00, 5'd2, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd6, 8'h00, 5'd1, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd6, 8'h00, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd6, 8'h00, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd3, 8'h77, 5'd1, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input int op, input logic [7:0] arg);
    @(negedge clk);
    case (op)
      1: begin cfg_valid = 1'b1; cfg_enable = arg[4]; cfg_thresh = arg[3:0]; end
      2: to_host = arg[0];
      3: begin host_wr = 1'b1; host_wdata = arg; end
      4: host_rd = 1'b1;
      5: begin core_wr = 1'b1; core_wdata = arg; end
      6: core_rd = 1'b1;
      default: ;
    endcase
    @(posedge clk);
    #1;
    cfg_valid = 1'b0; host_wr = 1'b0; host_rd = 1'b0; core_wr = 1'b0; core_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1ms;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    cfg_valid = 0; cfg_enable = 0; cfg_thresh = 0; to_host = 0;
    host_wr = 0; host_rd = 0; core_wr = 0; core_rd = 0;
    host_wdata = 0; core_wdata = 0;
    rst_n = 1'b0;
    do_reset();

    // R2 reset state
    chk("R2 level", int'(fill_level), 0);
    chk("R2 rqm", int'(rqm), 1);
    chk("R2 svc_req", int'(svc_req), 1);
    chk("R2 flags", int'({overrun, underrun}), 0);

    // table walk: R3 R4 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      apply(int'(VEC[i][19:17]), VEC[i][16:9]);
      chk($sformatf("R8/R9 level row %0d", i), int'(fill_level), int'(VEC[i][8:4]));
      chk($sformatf("R8/R9 svc_req row %0d", i), int'(svc_req), int'(VEC[i][3]));
      chk($sformatf("R6 rqm row %0d", i), int'(rqm), int'(VEC[i][2]));
      chk($sformatf("R10 overrun row %0d", i), int'(overrun), int'(VEC[i][1]));
      chk($sformatf("R11 underrun row %0d", i), int'(underrun), int'(VEC[i][0]));
    end

    // R2: reset returns to bypass mode after buffered use
    do_reset();
    to_host = 1'b0;
    apply(3, 8'h5A);
    apply(3, 8'h6B);
    chk("R3 bypass holds one byte", int'(fill_level), 1);
    chk("R1 head byte", int'(core_rdata), 8'h5A);
    apply(4, 8'h00);
    chk("R7 host read ignored when dio=0", int'(fill_level), 1);

    // R8 threshold 15, fill to full, then overrun
    apply(1, 8'h1F);
    chk("R4 configure flushes", int'(fill_level), 0);
    to_host = 1'b1;
    #1;
    chk("R6 dio follows direction", int'(dio), 1);
    for (int k = 0; k < 14; k++) apply(5, 8'(k));
    chk("R8 no request at 14 of 15", int'(svc_req), 0);
    apply(5, 8'd14);
    chk("R8 request at 15", int'(svc_req), 1);
    apply(5, 8'd15);
    chk("R1 level 16", int'(fill_level), 16);
    apply(5, 8'd99);
    chk("R10 overrun on full", int'(overrun), 1);
    chk("R10 dropped byte", int'(fill_level), 16);
    apply(3, 8'hEE);
    chk("R7 host write ignored when dio=1", int'(fill_level), 16);
    for (int k = 0; k < 16; k++) begin
      chk("R1 order", int'(host_rdata), k);
      apply(4, 8'h00);
    end
    chk("R6 rqm low when empty", int'(rqm), 0);
    apply(4, 8'h00);
    chk("R7 host read ignored when rqm=0", int'(fill_level), 0);
    chk("R10 overrun still set", int'(overrun), 1);

    // R9 threshold 8 on free space
    apply(1, 8'h18);
    chk("R4 configure clears overrun", int'(overrun), 0);
    to_host = 1'b0;
    for (int k = 0; k < 8; k++) apply(3, 8'(k));
    chk("R9 request at free 8", int'(svc_req), 1);
    apply(3, 8'd8);
    chk("R9 no request at free 7", int'(svc_req), 0);
    apply(5, 8'h33);
    chk("R7 core write ignored when to_host=0", int'(fill_level), 9);

    // R5 threshold 0 acts as 1
    apply(1, 8'h10);
    for (int k = 0; k < 15; k++) apply(3, 8'(k));
    chk("R5 request with one free", int'(svc_req), 1);
    apply(3, 8'd15);
    chk("R5 no request when full", int'(svc_req), 0);
    chk("R6 rqm low when full", int'(rqm), 0);

    // R11 underrun then configure clears it
    apply(1, 8'h10);
    apply(6, 8'h00);
    chk("R11 underrun on empty", int'(underrun), 1);
    apply(1, 8'h00);
    chk("R4 configure clears underrun", int'(underrun), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule